// File: doc/BRIEF.md
# Four-Mode Shift Register with 1001 Detector

This block is a small register of flip-flops, all on one clock, that performs one of four operations at each rising clock edge: it keeps its contents, moves every bit one place toward the right end, moves every bit one place toward the left end, or takes a whole word from a parallel input. A two-bit operation select picks the operation. A synchronous clear input overrides the select and empties the register.

Each end of the register has a serial input and a serial output, so several copies can be chained in either direction. The whole word is also visible on a parallel output. A detector raises a flag while the register holds the bit sequence 1001. When data is shifted right, the newest serial bit enters at the left end, so the flag marks the arrival of the serial pattern 1, 0, 0, 1.

Internally the select and clear are first decoded into one named operation. The operations are OP_CLEAR, OP_HOLD, OP_SHR, OP_SHL and OP_LOAD. Every operation can follow every other on any edge: the operation is chosen afresh each cycle from `clr` and `mode_sel`, and no state carries over between cycles.

Top module: `usr_detect`

## Requirements
- R1: When `clr` is 1 at a rising edge, `q_out` is all zeros after that edge. This holds for any `mode_sel`.
- R2: When `clr` is 0 and `mode_sel` is 2'b00, `q_out` keeps its value across the edge.
- R3: When `clr` is 0 and `mode_sel` is 2'b01 (shift right), `q_out` becomes {`ser_in_left`, old `q_out[W-1:1]`}. Bit W-1 is the left end.
- R4: When `clr` is 0 and `mode_sel` is 2'b10 (shift left), `q_out` becomes {old `q_out[W-2:0]`, `ser_in_right`}. Bit 0 is the right end.
- R5: When `clr` is 0 and `mode_sel` is 2'b11 (load), `q_out` becomes `load_data`.
- R6: `ser_out_left` always equals `q_out[W-1]`, and `ser_out_right` always equals `q_out[0]`.
- R7: `seq_hit` is 1 in the same cycle that `q_out[W-1:W-4]` reads 4'b1001, and it is 0 otherwise. During shift right this means the last four serial inputs arrived in the order 1, 0, 0, 1.
- R8: Clear takes priority over a parallel load that is requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| clr | input | 1 | Synchronous clear, active high |
| mode_sel | input | 2 | Operation select: 00 hold, 01 shift right, 10 shift left, 11 load |
| ser_in_left | input | 1 | Serial bit entering at the left end on shift right |
| ser_in_right | input | 1 | Serial bit entering at the right end on shift left |
| load_data | input | W | Parallel load word |
| q_out | output | W | Register contents |
| ser_out_left | output | 1 | Left end bit |
| ser_out_right | output | 1 | Right end bit |
| seq_hit | output | 1 | High while the top four bits are 1001 |

## Verification
Long random runs mix all four select codes with occasional clears. Each cycle is compared against a bench model, which separates the shift directions and shows whether each end-fill input goes to the correct end.

Directed serial streams of 1,0,0,1 and near misses such as 1,0,1,1 are shifted in from the left. These show whether the flag matches on the complete pattern only. Loading the 1001 word and then moving it one place left shows that the flag tracks the contents and not the operation.

A clear asserted together with a load of all ones shows whether clear is decoded ahead of the select.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_SHR   = 3'd1,
        OP_SHL   = 3'd2,
        OP_LOAD  = 3'd3,
        OP_CLEAR = 3'd4
    } usr_op_e;

    localparam logic [3:0] HIT_PATTERN = 4'b1001;

endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
    import usr_pkg::*;
(
    input  logic       clr,
    input  logic [1:0] mode_sel,
    output usr_op_e    op
);

    always_comb begin
        if (clr) begin
            op = OP_CLEAR;
        end else begin
            unique case (mode_sel)
                2'b00:   op = OP_HOLD;
                2'b01:   op = OP_SHR;
                2'b10:   op = OP_SHL;
                default: op = OP_LOAD;
            endcase
        end
    end

    // R8: the decoded operation is clear whenever clr is high, even if load is selected
    always_comb begin
        a_r8_clear_first : assert (!clr || op == OP_CLEAR);
    end

endmodule

// File: rtl/usr_cell.sv
module usr_cell
    import usr_pkg::*;
(
    input  logic    clk,
    input  usr_op_e op,
    input  logic    from_left,
    input  logic    from_right,
    input  logic    load_bit,
    output logic    bit_q
);

    logic bit_d;

    always_comb begin
        unique case (op)
            OP_CLEAR: bit_d = 1'b0;
            OP_HOLD:  bit_d = bit_q;
            OP_SHR:   bit_d = from_left;
            OP_SHL:   bit_d = from_right;
            OP_LOAD:  bit_d = load_bit;
            default:  bit_d = bit_q;
        endcase
    end

    always_ff @(posedge clk) begin
        bit_q <= bit_d;
    end

endmodule

// File: rtl/usr_seq_det.sv
module usr_seq_det
    import usr_pkg::*;
(
    input  logic [3:0] window,
    output logic       hit
);

    assign hit = (window == HIT_PATTERN);

endmodule

// File: rtl/usr_detect.sv
module usr_detect
    import usr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [1:0]   mode_sel,
    input  logic         ser_in_left,
    input  logic         ser_in_right,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] q_out,
    output logic         ser_out_left,
    output logic         ser_out_right,
    output logic         seq_hit
);

    localparam int MSB = W - 1;

    usr_op_e      op;
    logic [W-1:0] cells;
    logic [W-1:0] left_nb;
    logic [W-1:0] right_nb;

    usr_mode_dec u_dec (
        .clr      (clr),
        .mode_sel (mode_sel),
        .op       (op)
    );

    generate
        for (genvar i = 0; i < W; i++) begin : g_cell
            if (i == MSB) begin : g_left_end
                assign left_nb[i] = ser_in_left;
            end else begin : g_left_inner
                assign left_nb[i] = cells[i+1];
            end
            if (i == 0) begin : g_right_end
                assign right_nb[i] = ser_in_right;
            end else begin : g_right_inner
                assign right_nb[i] = cells[i-1];
            end
            usr_cell u_cell (
                .clk        (clk),
                .op         (op),
                .from_left  (left_nb[i]),
                .from_right (right_nb[i]),
                .load_bit   (load_data[i]),
                .bit_q      (cells[i])
            );
        end
    endgenerate

    usr_seq_det u_det (
        .window (cells[MSB -: 4]),
        .hit    (seq_hit)
    );

    assign q_out         = cells;
    assign ser_out_left  = cells[MSB];
    assign ser_out_right = cells[0];

    a_r1_clear_zeroes : assert property (@(posedge clk)
        clr |=> (q_out == '0));

    a_r2_hold_keeps : assert property (@(posedge clk) disable iff (clr)
        (mode_sel == 2'b00) |=> $stable(q_out));

    a_r3_shift_right : assert property (@(posedge clk) disable iff (clr)
        (mode_sel == 2'b01) |=> (q_out == {$past(ser_in_left), $past(q_out[MSB:1])}));

    a_r4_shift_left : assert property (@(posedge clk) disable iff (clr)
        (mode_sel == 2'b10) |=> (q_out == {$past(q_out[MSB-1:0]), $past(ser_in_right)}));

    a_r5_load : assert property (@(posedge clk) disable iff (clr)
        (mode_sel == 2'b11) |=> (q_out == $past(load_data)));

    // R7: a hit implies both outer bits of the window are ones
    a_r7_hit_ends : assert property (@(posedge clk)
        seq_hit |-> (q_out[MSB] && q_out[MSB-3]));

endmodule

// File: tb/sim_usr_detect.sv
module sim_usr_detect;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr;
    logic [1:0]   mode_sel;
    logic         ser_in_left;
    logic         ser_in_right;
    logic [W-1:0] load_data;
    logic [W-1:0] q_out;
    logic         ser_out_left;
    logic         ser_out_right;
    logic         seq_hit;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;
    logic [W-1:0] model;

    always #2 clk = ~clk;

    usr_detect #(.W(W)) u0 (
        .clk           (clk),
        .clr           (clr),
        .mode_sel      (mode_sel),
        .ser_in_left   (ser_in_left),
        .ser_in_right  (ser_in_right),
        .load_data     (load_data),
        .q_out         (q_out),
        .ser_out_left  (ser_out_left),
        .ser_out_right (ser_out_right),
        .seq_hit       (seq_hit)
    );

    function automatic logic [W-1:0] next_val(logic [W-1:0] cur, logic c, logic [1:0] s,
                                              logic li, logic ri, logic [W-1:0] ld);
        if (c) return '0;
        case (s)
            2'b00:   return cur;
            2'b01:   return {li, cur[W-1:1]};
            2'b10:   return {cur[W-2:0], ri};
            default: return ld;
        endcase
    endfunction

    function automatic string req_of(logic c, logic [1:0] s);
        if (c) return "R1";
        case (s)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive at falling edge, apply rising edge, sample 1 ns later
    task automatic step(logic c, logic [1:0] s, logic li, logic ri, logic [W-1:0] ld);
        string r;
        @(negedge clk);
        clr = c; mode_sel = s; ser_in_left = li; ser_in_right = ri; load_data = ld;
        r = req_of(c, s);
        model = next_val(model, c, s, li, ri, ld);
        @(posedge clk);
        #1;
        check(r, q_out, model);
        check("R6", {3'b0, ser_out_left}, {3'b0, model[W-1]});
        check("R6", {3'b0, ser_out_right}, {3'b0, model[0]});
        check("R7", {3'b0, seq_hit}, {3'b0, (model == 4'b1001)});
    endtask

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        model = '0;
        clr = 1'b0; mode_sel = 2'b00; ser_in_left = 1'b0; ser_in_right = 1'b0; load_data = '0;

        // R1: reset state via clear
        step(1'b1, 2'b00, 1'b0, 1'b0, '0);
        check("R1", {3'b0, seq_hit}, 4'b0000);

        // R7: serial 1,0,0,1 from the left
        step(1'b0, 2'b01, 1'b1, 1'b0, '0);
        step(1'b0, 2'b01, 1'b0, 1'b0, '0);
        step(1'b0, 2'b01, 1'b0, 1'b0, '0);
        step(1'b0, 2'b01, 1'b1, 1'b0, '0);
        check("R7", {3'b0, seq_hit}, 4'b0001);
        // R2: hold keeps pattern
        step(1'b0, 2'b00, 1'b0, 1'b1, 4'hF);
        // near miss 1,0,1,1
        step(1'b0, 2'b01, 1'b1, 1'b0, '0);
        step(1'b0, 2'b01, 1'b0, 1'b0, '0);
        step(1'b0, 2'b01, 1'b1, 1'b0, '0);
        step(1'b0, 2'b01, 1'b1, 1'b0, '0);
        check("R7", {3'b0, seq_hit}, 4'b0000);

        // R5 load of 1001, then R4 shift left breaks the match
        step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1001);
        step(1'b0, 2'b10, 1'b0, 1'b1, '0);
        check("R4", q_out, 4'b0011);

        // R8: clear beats load
        step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1111);
        step(1'b1, 2'b11, 1'b1, 1'b1, 4'b1111);
        check("R8", q_out, 4'b0000);

        // random mix
        for (int n = 0; n < 2000; n++) begin
            logic c;
            c = ($urandom_range(0, 15) == 0);
            step(c, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule